// File: doc/BRIEF.md
# Transmit clock source selector

This block chooses which of three candidate clocks drives the transmit side of one T1/E1 line. The three candidates are an external transmit clock input, the clock recovered from the received line signal, and a scaled copy of the master clock. Each arrives as a one-cycle strobe already synchronised into a single fast system clock, one strobe per rising edge of that clock. The block emits one transmit-clock strobe, a code for the source now in use, and a sticky flag that records a loss of the external clock.

A 2-bit mode input sets the policy. Two modes use a fixed source and ignore the external input. One mode always uses the external input. The fourth mode uses the external input but watches it. If the input goes quiet for a channel time, measured in recovered-clock strobes, the block falls back to the recovered clock. It returns to the external input only after that input has been steady again for a while.

The strobes are clock events and not data, so there is no valid/ready handshake and no back-pressure. Every port is a plain control, strobe or status signal. Any change of source waits for an edge of the new source. As a result, the output never carries a shortened period or two strobes that belong to one edge.

Top module: `txclk_src_sel`

## Requirements
- R1: While reset is asserted and right after it is released, `tx_clk_stb` is 0, `tx_src` is 2'b00 (pin), `tx_clk_lost` is 0, the mode in use is 2'b00, and both activity counters are zero.
- R2: In mode 2'b00, `tx_clk_stb` repeats `ext_clk_stb` one clock later. The recovered and master strobes have no effect, and a silent pin never causes a failover.
- R3: In mode 2'b10, `tx_src` becomes 2'b10 (master) and `tx_clk_stb` repeats `mst_clk_stb` one clock later. Pin and recovered strobes are ignored.
- R4: In mode 2'b11, `tx_src` becomes 2'b01 (recovered) and `tx_clk_stb` repeats `rec_clk_stb` one clock later. Pin and master strobes are ignored.
- R5: In mode 2'b01, the pin stays selected as long as no run of 8 recovered strobes passes without a pin edge. Any pin edge restarts that run, so 7 recovered strobes are not enough to cause a failover.
- R6: In mode 2'b01, the 8th consecutive recovered strobe without a pin edge starts a failover. `tx_clk_lost` is set, and the selection moves to recovered (`tx_src` = 2'b01).
- R7: After a failover, the pin is selected again once 8 consecutive pin edges have each followed the previous pin edge with at most one recovered strobe in between. A pin edge that follows two or more recovered strobes restarts this count.
- R8: `tx_src` changes only in a cycle in which `tx_clk_stb` is 1, because the switch happens on the new source's first strobe. Until that strobe arrives, strobes of the old source are withheld. `tx_clk_stb` is 1 only if the source shown by `tx_src` strobed in the previous cycle.
- R9: `tx_clk_lost` stays set until a cycle with `loss_clr` = 1, which clears it. If a failover and a clear happen in the same cycle, the flag stays set.
- R10: The mode input is registered on the next clock edge. A strobe of the newly chosen source presented in the cycle after that edge already drives the output. Any change of mode clears both activity counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than any candidate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Source policy: 00 pin, 01 pin with failover, 10 master, 11 recovered |
| ext_clk_stb | input | 1 | One-cycle strobe per rising edge of the external transmit clock |
| rec_clk_stb | input | 1 | One-cycle strobe per rising edge of the recovered receive clock |
| mst_clk_stb | input | 1 | One-cycle strobe per rising edge of the scaled master clock |
| loss_clr | input | 1 | Write-one-to-clear pulse for `tx_clk_lost` |
| tx_clk_stb | output | 1 | Selected transmit clock strobe, one clock after the source strobe |
| tx_src | output | 2 | Active source: 00 pin, 01 recovered, 10 master |
| tx_clk_lost | output | 1 | Sticky flag, set when a failover to the recovered clock occurs |

## Verification
The hardest state to reach from the ports is the return from failover. It is easy to make the pin look healthy too soon by accident, so the return count could appear correct without really being tested. The bench first forces a failover with exactly 8 recovered strobes, then feeds a run of fast pin edges. It breaks that run with two recovered strobes and rebuilds it with alternating recovered and pin strobes. The status must stay on recovered after 7 good edges and switch only on the pin edge that follows the 8th. The pending window between a decision and the new source's first strobe is also probed: old-source strobes are sent inside it and must be withheld.

// File: rtl/txclk_sel_pkg.sv
`timescale 1ns/1ps
package txclk_sel_pkg;

  typedef enum logic [1:0] {
    MODE_PIN_ONLY     = 2'b00,
    MODE_PIN_FAILOVER = 2'b01,
    MODE_MASTER       = 2'b10,
    MODE_RECOVERED    = 2'b11
  } tx_mode_e;

  typedef enum logic [1:0] {
    SRC_PIN = 2'b00,
    SRC_REC = 2'b01,
    SRC_MST = 2'b10
  } tx_src_e;

  // Strobe of a given candidate source.
  function automatic logic src_strobe(tx_src_e s, logic pin, logic rec, logic mst);
    case (s)
      SRC_PIN: src_strobe = pin;
      SRC_REC: src_strobe = rec;
      SRC_MST: src_strobe = mst;
      default: src_strobe = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/txclk_activity_mon.sv
`timescale 1ns/1ps
// Watches the external pin against the recovered clock.
// idle_cnt: recovered strobes since the last pin edge (saturating).
// good_cnt: consecutive pin edges each preceded by at most one recovered strobe.
module txclk_activity_mon #(
  parameter int IDLE_RUN = 8,
  parameter int GOOD_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pin_stb,
  input  logic rec_stb,
  output logic pin_dead,
  output logic pin_steady
);
  localparam int IW = $clog2(IDLE_RUN + 1);
  localparam int GW = $clog2(GOOD_RUN + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_RUN);
  localparam logic [GW-1:0] GOOD_MAX = GW'(GOOD_RUN);
  localparam logic [IW-1:0] ONE_PERIOD = IW'(1);

  logic [IW-1:0] idle_cnt;
  logic [GW-1:0] good_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idle_cnt <= '0;
    end else if (pin_stb) begin
      idle_cnt <= '0;
    end else if (rec_stb && idle_cnt != IDLE_MAX) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      good_cnt <= '0;
    end else if (pin_stb) begin
      if (idle_cnt > ONE_PERIOD) begin
        good_cnt <= '0;
      end else if (good_cnt != GOOD_MAX) begin
        good_cnt <= good_cnt + 1'b1;
      end
    end
  end

  assign pin_dead   = (idle_cnt == IDLE_MAX);
  assign pin_steady = (good_cnt == GOOD_MAX);

endmodule

// File: rtl/txclk_failover_ctl.sv
`timescale 1ns/1ps
// Registers the mode, runs the failover decision and the sticky loss flag,
// and names the source the output should move to.
module txclk_failover_ctl
  import txclk_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] mode,
  input  logic     pin_dead,
  input  logic     pin_steady,
  input  logic     loss_clr,
  output tx_mode_e mode_q,
  output tx_src_e  want_src,
  output logic     fail_evt,
  output logic     cnt_clr,
  output logic     loss_flag
);
  logic mode_chg;
  logic ret_evt;
  logic on_rec;

  assign mode_chg = (tx_mode_e'(mode) != mode_q);
  assign fail_evt = !mode_chg && (mode_q == MODE_PIN_FAILOVER) && !on_rec && pin_dead;
  assign ret_evt  = !mode_chg && (mode_q == MODE_PIN_FAILOVER) &&  on_rec && pin_steady;
  assign cnt_clr  = mode_chg || fail_evt || ret_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_PIN_ONLY;
      on_rec <= 1'b0;
    end else begin
      mode_q <= tx_mode_e'(mode);
      if (mode_chg)      on_rec <= 1'b0;
      else if (fail_evt) on_rec <= 1'b1;
      else if (ret_evt)  on_rec <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        loss_flag <= 1'b0;
    else if (fail_evt) loss_flag <= 1'b1;
    else if (loss_clr) loss_flag <= 1'b0;
  end

  always_comb begin
    case (mode_q)
      MODE_PIN_ONLY:     want_src = SRC_PIN;
      MODE_PIN_FAILOVER: want_src = on_rec ? SRC_REC : SRC_PIN;
      MODE_MASTER:       want_src = SRC_MST;
      default:           want_src = SRC_REC;
    endcase
  end

endmodule

// File: rtl/txclk_glitchless_mux.sv
`timescale 1ns/1ps
// Moves the active source only on a strobe of the requested source and
// withholds old-source strobes while a move is pending.
module txclk_glitchless_mux
  import txclk_sel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tx_src_e want_src,
  input  logic    pin_stb,
  input  logic    rec_stb,
  input  logic    mst_stb,
  output tx_src_e act_src,
  output logic    tx_stb
);
  tx_src_e act_nxt;
  logic    tx_nxt;
  logic    new_stb;
  logic    cur_stb;

  assign new_stb = src_strobe(want_src, pin_stb, rec_stb, mst_stb);
  assign cur_stb = src_strobe(act_src,  pin_stb, rec_stb, mst_stb);

  always_comb begin
    act_nxt = act_src;
    tx_nxt  = 1'b0;
    if (want_src != act_src) begin
      if (new_stb) begin
        act_nxt = want_src;
        tx_nxt  = 1'b1;
      end
    end else begin
      tx_nxt = cur_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_src <= SRC_PIN;
      tx_stb  <= 1'b0;
    end else begin
      act_src <= act_nxt;
      tx_stb  <= tx_nxt;
    end
  end

endmodule

// File: rtl/txclk_src_sel.sv
`timescale 1ns/1ps
module txclk_src_sel
  import txclk_sel_pkg::*;
#(
  parameter int IDLE_RUN = 8,
  parameter int GOOD_RUN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       ext_clk_stb,
  input  logic       rec_clk_stb,
  input  logic       mst_clk_stb,
  input  logic       loss_clr,
  output logic       tx_clk_stb,
  output logic [1:0] tx_src,
  output logic       tx_clk_lost
);
  tx_mode_e mode_q;
  tx_src_e  want_src;
  tx_src_e  act_src;
  logic     fail_evt;
  logic     cnt_clr;
  logic     pin_dead;
  logic     pin_steady;

  txclk_activity_mon #(
    .IDLE_RUN(IDLE_RUN),
    .GOOD_RUN(GOOD_RUN)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .pin_stb   (ext_clk_stb),
    .rec_stb   (rec_clk_stb),
    .pin_dead  (pin_dead),
    .pin_steady(pin_steady)
  );

  txclk_failover_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .pin_dead  (pin_dead),
    .pin_steady(pin_steady),
    .loss_clr  (loss_clr),
    .mode_q    (mode_q),
    .want_src  (want_src),
    .fail_evt  (fail_evt),
    .cnt_clr   (cnt_clr),
    .loss_flag (tx_clk_lost)
  );

  txclk_glitchless_mux u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_src(want_src),
    .pin_stb (ext_clk_stb),
    .rec_stb (rec_clk_stb),
    .mst_stb (mst_clk_stb),
    .act_src (act_src),
    .tx_stb  (tx_clk_stb)
  );

  assign tx_src = act_src;

endmodule

// File: rtl/txclk_src_sel_chk.sv
`timescale 1ns/1ps
module txclk_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_clk_stb,
  input logic       rec_clk_stb,
  input logic       mst_clk_stb,
  input logic       loss_clr,
  input logic       tx_clk_stb,
  input logic [1:0] tx_src,
  input logic       tx_clk_lost,
  input logic [1:0] mode_q,
  input logic       fail_evt
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: the status never shows the unused code
  p_src_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_src != 2'b11);

  // R2: the pin-only mode never starts a failover
  p_pin_only_no_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> !fail_evt);

  // R8: an output strobe comes from the source shown one cycle earlier
  p_tx_from_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && tx_clk_stb) |->
      ((tx_src == 2'b00) ? $past(ext_clk_stb) :
       (tx_src == 2'b01) ? $past(rec_clk_stb) : $past(mst_clk_stb)));

  // R8: the source changes only together with a strobe of the new source
  p_switch_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && tx_src != $past(tx_src)) |-> tx_clk_stb);

  // R6: a failover decision leaves the loss flag set
  p_fail_sets_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(fail_evt)) |-> tx_clk_lost);

  // R9: only a clear pulse can drop the loss flag
  p_loss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(tx_clk_lost) && !$past(loss_clr)) |-> tx_clk_lost);

endmodule

bind txclk_src_sel txclk_src_sel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_clk_stb(ext_clk_stb),
  .rec_clk_stb(rec_clk_stb),
  .mst_clk_stb(mst_clk_stb),
  .loss_clr   (loss_clr),
  .tx_clk_stb (tx_clk_stb),
  .tx_src     (tx_src),
  .tx_clk_lost(tx_clk_lost),
  .mode_q     (mode_q),
  .fail_evt   (fail_evt)
);

// File: tb/txclk_src_sel_tb.sv
`timescale 1ns/1ps
module txclk_src_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       ext_clk_stb = 1'b0;
  logic       rec_clk_stb = 1'b0;
  logic       mst_clk_stb = 1'b0;
  logic       loss_clr = 1'b0;
  logic       tx_clk_stb;
  logic [1:0] tx_src;
  logic       tx_clk_lost;

  int n_checks = 0;
  int n_fail   = 0;
  logic last_tx;
  logic [1:0] last_src;

  always #10 clk = ~clk;

  txclk_src_sel u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .ext_clk_stb(ext_clk_stb),
    .rec_clk_stb(rec_clk_stb),
    .mst_clk_stb(mst_clk_stb),
    .loss_clr   (loss_clr),
    .tx_clk_stb (tx_clk_stb),
    .tx_src     (tx_src),
    .tx_clk_lost(tx_clk_lost)
  );

  // {mode[1:0], ext, rec, mst, expected tx, expected src[1:0]}
  localparam logic [7:0] VEC [0:7] = '{
    8'b00_100_1_00,
    8'b00_011_0_00,
    8'b10_110_0_10,
    8'b10_001_1_10,
    8'b11_101_0_01,
    8'b11_010_1_01,
    8'b01_100_1_00,
    8'b01_011_0_00
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One-cycle strobe pattern, output captured after it, then one quiet cycle.
  task automatic pulse(input logic e, input logic r, input logic m);
    ext_clk_stb = e; rec_clk_stb = r; mst_clk_stb = m;
    tick();
    last_tx  = tx_clk_stb;
    last_src = tx_src;
    ext_clk_stb = 1'b0; rec_clk_stb = 1'b0; mst_clk_stb = 1'b0;
    tick();
  endtask

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00:   req_of = "R2 pin only";
      2'b10:   req_of = "R3 master";
      2'b11:   req_of = "R4 recovered";
      default: req_of = "R5 pin with failover";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1: state during and just after reset
    check("R1 tx during reset", tx_clk_stb, 0);
    check("R1 src during reset", tx_src, 0);
    check("R1 loss during reset", tx_clk_lost, 0);
    rst_n = 1'b1;
    tick();
    check("R1 src after release", tx_src, 0);
    check("R1 loss after release", tx_clk_lost, 0);

    // Table: each mode and strobe pattern (R10 timing: prime one cycle after mode)
    for (int i = 0; i < 8; i++) begin
      mode = VEC[i][7:6];
      tick();
      pulse(1'b1, 1'b1, 1'b1);
      pulse(VEC[i][5], VEC[i][4], VEC[i][3]);
      check({req_of(VEC[i][7:6]), " tx"}, last_tx, VEC[i][2]);
      check({req_of(VEC[i][7:6]), " src"}, last_src, VEC[i][1:0]);
    end

    // R5: a pin edge restarts the silence run
    mode = 2'b01;
    tick();
    pulse(1'b1, 1'b0, 1'b0);
    repeat (5) pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    repeat (7) pulse(1'b0, 1'b1, 1'b0);
    check("R5 still on pin after 7", tx_src, 0);
    check("R5 no loss after 7", tx_clk_lost, 0);

    // R6: the 8th silent recovered strobe fails over
    pulse(1'b0, 1'b1, 1'b0);
    check("R6 loss set", tx_clk_lost, 1);
    // R8: pending switch withholds pin strobes
    pulse(1'b1, 1'b0, 1'b0);
    check("R8 pin withheld while pending", last_tx, 0);
    check("R8 src held while pending", last_src, 0);
    pulse(1'b0, 1'b1, 1'b0);
    check("R6 switch strobe", last_tx, 1);
    check("R6 src recovered", last_src, 1);

    // R7: gap restarts the good-edge count
    repeat (5) pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 7; k++) begin
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b1, 1'b0, 1'b0);
    end
    check("R7 still recovered after 7 good", tx_src, 1);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    check("R7 waits for pin strobe", tx_src, 1);
    pulse(1'b1, 1'b0, 1'b0);
    check("R7 return strobe", last_tx, 1);
    check("R7 back on pin", last_src, 0);

    // R9: sticky, then cleared by a pulse
    check("R9 loss still set", tx_clk_lost, 1);
    loss_clr = 1'b1;
    tick();
    loss_clr = 1'b0;
    check("R9 loss cleared", tx_clk_lost, 0);

    // R10: a mode change clears the silence run
    repeat (7) pulse(1'b0, 1'b1, 1'b0);
    mode = 2'b00;
    tick();
    mode = 2'b01;
    tick();
    repeat (7) pulse(1'b0, 1'b1, 1'b0);
    check("R10 counter cleared src", tx_src, 0);
    check("R10 counter cleared loss", tx_clk_lost, 0);

    // R8: move from pin to master only on a master strobe
    mode = 2'b00;
    tick();
    pulse(1'b1, 1'b0, 1'b0);
    mode = 2'b10;
    tick();
    pulse(1'b1, 1'b0, 1'b0);
    check("R8 old pin strobe withheld", last_tx, 0);
    check("R8 src unchanged before master", last_src, 0);
    pulse(1'b0, 1'b1, 1'b0);
    check("R8 recovered ignored", last_tx, 0);
    pulse(1'b0, 1'b0, 1'b1);
    check("R8 master strobe passes", last_tx, 1);
    check("R8 src master", last_src, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule